// File: doc/BRIEF.md
# Wake Event Signal Generator

This block collects wake conditions from two Ethernet PHYs and from a host MAC's wake-on-LAN detector. Each PHY reports an energy-on flag that counts only when the PHY's own mask bit and the block's per-PHY energy-detect enable are set. The MAC reports a wake-frame flag and a magic-packet flag, each with its own enable, and both sit behind a common wake-on-LAN enable. Every qualified condition lands in a sticky status bit. Software clears the bit by writing a 1 to it.

The OR of the sticky bits forms the power-management event condition. When the pin is enabled, this condition drives an external event pin. The pin either follows the status level or emits one fixed-length pulse per new event, with programmable active polarity and a choice between push-pull and open-drain driving. Open-drain is modelled as a separate output-enable. The same condition also sets a sticky interrupt status bit. That bit reaches the system interrupt output only through its own enable and a global interrupt enable, and the output is ORed with other system interrupts.

Software reaches all control and status bits through a small write/read register port with four word addresses.

Top module: `wake_event_gen`

## Requirements
- R1: After synchronous reset, all control, enable and status bits read 0, `pme_out` is 1 (active-low idle), `pme_oe` is 1 (push-pull) and `irq` is 0 while `other_irq` is 0.
- R2: Energy status for PHY i (address 0, bit 16+i) sets only when `phy_energy_on[i]`, `phy_energy_mask[i]` and energy enable i (address 0, bit 14+i) are all 1. An unmasked or disabled PHY leaves the bit at 0.
- R3: Wake-on-LAN status (address 0, bit 5) sets when wake-on-LAN enable (address 0, bit 9) is 1 and either `mac_wake_frame` with frame enable (address 1, bit 2) or `mac_magic_pkt` with magic enable (address 1, bit 1) is 1.
- R4: Status bits hold until software writes 1 to them. When the source is still active in the cycle of the clearing write, the bit stays set.
- R5: With pin enable (address 0, bit 1) at 0, the pin is held at its inactive level.
- R6: In level mode (address 0, bit 3 = 0) with the pin enabled, the pin is active exactly while any status bit is set.
- R7: In pulse mode (address 0, bit 3 = 1) a new event makes the pin active for exactly PULSE_CYCLES clock cycles. A further event while the pulse runs neither extends nor restarts it.
- R8: Polarity (address 0, bit 2): 1 means active-high, 0 means active-low.
- R9: In open-drain mode (address 0, bit 6 = 1), `pme_oe` is 1 only while the pin is active. In push-pull mode it is always 1.
- R10: While any status bit is set, interrupt status (address 2, bit 17) is set. That bit clears by writing 1 to it, and the set takes priority over the clear.
- R11: `irq` is 1 when interrupt status bit 17, interrupt enable (address 3, bit 17) and global enable (address 3, bit 8) are all 1, or when `other_irq` is 1.
- R12: `reg_rdata` returns the addressed register one cycle after `reg_addr` is presented. Address 1 bits 6 and 5 show the live `mac_wake_frame` and `mac_magic_pkt` inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| phy_energy_on | input | 2 | Per-PHY energy-on flags |
| phy_energy_mask | input | 2 | Per-PHY energy-on mask bits |
| mac_wake_frame | input | 1 | MAC wake frame received |
| mac_magic_pkt | input | 1 | MAC magic packet received |
| other_irq | input | 1 | Other system interrupt sources, ORed |
| pme_out | output | 1 | Event pin level |
| pme_oe | output | 1 | Event pin output enable |
| irq | output | 1 | System interrupt |

## Verification
The bench holds a source active while software writes the clearing 1. A design that let the clear win would drop an event that is still pending, both in the source status and in the interrupt status. It raises a second event in the middle of a running pulse. A counter that reloads would stretch the pulse beyond PULSE_CYCLES, and a design without edge qualification would fire a second pulse afterwards. It also drives energy flags with the mask or the enable missing, and packets without their own enable, so that a gate that is left out shows up as a status bit set in error. Polarity and open-drain settings are checked in both pin states, because an inverted enable would float the pin while it is active.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int NUM_PHY = 2;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] A_PMC  = 2'd0;
  localparam logic [ADDR_W-1:0] A_MACW = 2'd1;
  localparam logic [ADDR_W-1:0] A_ISTS = 2'd2;
  localparam logic [ADDR_W-1:0] A_IEN  = 2'd3;

  // power control word
  localparam int B_PIN_EN     = 1;
  localparam int B_PIN_POL    = 2;
  localparam int B_PULSE_MODE = 3;
  localparam int B_WOL_STS    = 5;
  localparam int B_PIN_OD     = 6;
  localparam int B_WOL_EN     = 9;
  localparam int B_ED_EN0     = 14;
  localparam int B_ED_STS0    = 16;
  // MAC wake word
  localparam int B_MAGIC_EN   = 1;
  localparam int B_FRAME_EN   = 2;
  localparam int B_MAGIC_RX   = 5;
  localparam int B_FRAME_RX   = 6;
  // interrupt words
  localparam int B_PME_INT    = 17;
  localparam int B_IRQ_EN     = 8;

  typedef struct packed {
    logic               pin_en;
    logic               pin_pol;
    logic               pulse_mode;
    logic               pin_od;
    logic               wol_en;
    logic [NUM_PHY-1:0] ed_en;
    logic               magic_en;
    logic               frame_en;
    logic               pme_int_en;
    logic               irq_en;
  } cfg_t;
endpackage

// File: rtl/wake_sticky.sv
module wake_sticky #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] sts
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) sts[i] <= 1'b0;
      else     sts[i] <= (sts[i] & ~clr[i]) | set[i];
    end
  end
endmodule

// File: rtl/wake_pulse.sv
module wake_pulse #(
  parameter int PULSE_CYCLES = 10_000_000,
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  output logic             busy,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
    else if (trig)       cnt <= CNT_W'(PULSE_CYCLES);
  end
  assign busy = (cnt != '0);
endmodule

// File: rtl/wake_pin_drv.sv
module wake_pin_drv (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic pol,
  input  logic od,
  output logic pme_out,
  output logic pme_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pme_out <= 1'b1;
      pme_oe  <= 1'b1;
    end else begin
      pme_out <= pol ? active : ~active;
      pme_oe  <= od ? active : 1'b1;
    end
  end
endmodule

// File: rtl/wake_event_gen.sv
module wake_event_gen
  import wake_pkg::*;
#(
  parameter int PULSE_CYCLES = 10_000_000,
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [NUM_PHY-1:0] phy_energy_on,
  input  logic [NUM_PHY-1:0] phy_energy_mask,
  input  logic               mac_wake_frame,
  input  logic               mac_magic_pkt,
  input  logic               other_irq,
  output logic               pme_out,
  output logic               pme_oe,
  output logic               irq
);
  cfg_t cfg;
  logic wr_pmc, wr_macw, wr_ists, wr_ien;
  logic [NUM_PHY-1:0] ed_set, ed_clr, ed_sts;
  logic wol_set, wol_clr, wol_sts;
  logic pint_set, pint_clr, pint_sts;
  logic pme_cond, new_evt, pulse_trig, pulse_busy, pin_active;
  logic [CNT_W-1:0] pulse_cnt;
  logic unused_wdata;

  assign wr_pmc  = reg_wr_en && (reg_addr == A_PMC);
  assign wr_macw = reg_wr_en && (reg_addr == A_MACW);
  assign wr_ists = reg_wr_en && (reg_addr == A_ISTS);
  assign wr_ien  = reg_wr_en && (reg_addr == A_IEN);
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else begin
      if (wr_pmc) begin
        cfg.pin_en     <= reg_wdata[B_PIN_EN];
        cfg.pin_pol    <= reg_wdata[B_PIN_POL];
        cfg.pulse_mode <= reg_wdata[B_PULSE_MODE];
        cfg.pin_od     <= reg_wdata[B_PIN_OD];
        cfg.wol_en     <= reg_wdata[B_WOL_EN];
        cfg.ed_en      <= reg_wdata[B_ED_EN0 +: NUM_PHY];
      end
      if (wr_macw) begin
        cfg.magic_en <= reg_wdata[B_MAGIC_EN];
        cfg.frame_en <= reg_wdata[B_FRAME_EN];
      end
      if (wr_ien) begin
        cfg.pme_int_en <= reg_wdata[B_PME_INT];
        cfg.irq_en     <= reg_wdata[B_IRQ_EN];
      end
    end
  end

  // event qualification
  for (genvar i = 0; i < NUM_PHY; i++) begin : g_phy
    assign ed_set[i] = cfg.ed_en[i] & phy_energy_on[i] & phy_energy_mask[i];
    assign ed_clr[i] = wr_pmc & reg_wdata[B_ED_STS0 + i];
  end
  assign wol_set = cfg.wol_en & ((mac_wake_frame & cfg.frame_en) |
                                 (mac_magic_pkt  & cfg.magic_en));
  assign wol_clr = wr_pmc & reg_wdata[B_WOL_STS];

  wake_sticky #(.N(NUM_PHY)) u_ed_sts (
    .clk(clk), .rst(rst), .set(ed_set), .clr(ed_clr), .sts(ed_sts));
  wake_sticky #(.N(1)) u_wol_sts (
    .clk(clk), .rst(rst), .set(wol_set), .clr(wol_clr), .sts(wol_sts));

  assign pme_cond = (|ed_sts) | wol_sts;
  assign new_evt  = (|(ed_set & ~ed_sts)) | (wol_set & ~wol_sts);

  // pulse / level selection
  assign pulse_trig = cfg.pin_en & cfg.pulse_mode & new_evt;

  wake_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst(rst), .trig(pulse_trig), .busy(pulse_busy), .cnt(pulse_cnt));

  assign pin_active = cfg.pin_en & (cfg.pulse_mode ? pulse_busy : pme_cond);

  wake_pin_drv u_drv (
    .clk(clk), .rst(rst), .active(pin_active), .pol(cfg.pin_pol),
    .od(cfg.pin_od), .pme_out(pme_out), .pme_oe(pme_oe));

  // interrupt path
  assign pint_set = pme_cond;
  assign pint_clr = wr_ists & reg_wdata[B_PME_INT];

  wake_sticky #(.N(1)) u_pint_sts (
    .clk(clk), .rst(rst), .set(pint_set), .clr(pint_clr), .sts(pint_sts));

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (pint_sts & cfg.pme_int_en & cfg.irq_en) | other_irq;
  end

  // read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      unique case (reg_addr)
        A_PMC: begin
          reg_rdata[B_PIN_EN]                 <= cfg.pin_en;
          reg_rdata[B_PIN_POL]                <= cfg.pin_pol;
          reg_rdata[B_PULSE_MODE]             <= cfg.pulse_mode;
          reg_rdata[B_WOL_STS]                <= wol_sts;
          reg_rdata[B_PIN_OD]                 <= cfg.pin_od;
          reg_rdata[B_WOL_EN]                 <= cfg.wol_en;
          reg_rdata[B_ED_EN0 +: NUM_PHY]      <= cfg.ed_en;
          reg_rdata[B_ED_STS0 +: NUM_PHY]     <= ed_sts;
        end
        A_MACW: begin
          reg_rdata[B_MAGIC_EN] <= cfg.magic_en;
          reg_rdata[B_FRAME_EN] <= cfg.frame_en;
          reg_rdata[B_MAGIC_RX] <= mac_magic_pkt;
          reg_rdata[B_FRAME_RX] <= mac_wake_frame;
        end
        A_ISTS: reg_rdata[B_PME_INT] <= pint_sts;
        A_IEN: begin
          reg_rdata[B_PME_INT] <= cfg.pme_int_en;
          reg_rdata[B_IRQ_EN]  <= cfg.irq_en;
        end
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wake_event_gen_chk.sv
module wake_event_gen_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr_en,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [1:0]       ed_sts,
  input logic             wol_sts,
  input logic             pint_sts,
  input logic             pme_cond,
  input logic             pin_en,
  input logic             pin_pol,
  input logic             pin_od,
  input logic             wol_en,
  input logic             magic_en,
  input logic             irq_en,
  input logic             mac_magic_pkt,
  input logic             other_irq,
  input logic [CNT_W-1:0] pulse_cnt,
  input logic             pme_out,
  input logic             pme_oe,
  input logic             irq
);
  assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (ed_sts[0] && !(reg_wr_en && reg_addr == 2'd0 && reg_wdata[16])) |=> ed_sts[0]);

  assert_wol_set_R3: assert property (@(posedge clk) disable iff (rst)
    (wol_en && magic_en && mac_magic_pkt) |=> wol_sts);

  assert_pin_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !pin_en |=> (pme_out == !$past(pin_pol)));

  assert_pulse_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (pulse_cnt != '0) |=> (pulse_cnt == $past(pulse_cnt) - 1'b1));

  assert_od_float_R9: assert property (@(posedge clk) disable iff (rst)
    (!pin_en && pin_od) |=> !pme_oe);

  assert_int_set_R10: assert property (@(posedge clk) disable iff (rst)
    pme_cond |=> pint_sts);

  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (rst)
    (!irq_en && !other_irq) |=> !irq);
endmodule

bind wake_event_gen wake_event_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ed_sts(ed_sts), .wol_sts(wol_sts),
  .pint_sts(pint_sts), .pme_cond(pme_cond), .pin_en(cfg.pin_en),
  .pin_pol(cfg.pin_pol), .pin_od(cfg.pin_od), .wol_en(cfg.wol_en),
  .magic_en(cfg.magic_en), .irq_en(cfg.irq_en), .mac_magic_pkt(mac_magic_pkt),
  .other_irq(other_irq), .pulse_cnt(pulse_cnt), .pme_out(pme_out),
  .pme_oe(pme_oe), .irq(irq));

// File: tb/wake_event_gen_test.sv
`timescale 1ns/1ps
module wake_event_gen_test;
  localparam int P = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  phy_energy_on = '0;
  logic [1:0]  phy_energy_mask = '0;
  logic        mac_wake_frame = 1'b0;
  logic        mac_magic_pkt = 1'b0;
  logic        other_irq = 1'b0;
  logic        pme_out, pme_oe, irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wake_event_gen #(.PULSE_CYCLES(P)) uut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .phy_energy_on(phy_energy_on),
    .phy_energy_mask(phy_energy_mask), .mac_wake_frame(mac_wake_frame),
    .mac_magic_pkt(mac_magic_pkt), .other_irq(other_irq),
    .pme_out(pme_out), .pme_oe(pme_oe), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    phy_energy_on = '0; phy_energy_mask = '0;
    mac_wake_frame = 1'b0; mac_magic_pkt = 1'b0; other_irq = 1'b0;
    idle(3);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 pme_out", 32'(pme_out), 32'd1);
    chk("R1 pme_oe", 32'(pme_oe), 32'd1);
    chk("R1 irq", 32'(irq), 32'd0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reg", d, 32'd0);
    end
  endtask

  task automatic t_energy();
    logic [31:0] d;
    do_reset();
    wr(2'd0, 32'h0000_4000);              // energy enable PHY0 only
    phy_energy_on = 2'b11; phy_energy_mask = 2'b00;
    idle(3);
    rd(2'd0, d);
    chk("R2 unmasked PHY0", 32'(d[16]), 32'd0);
    phy_energy_mask = 2'b11;
    idle(3);
    rd(2'd0, d);
    chk("R2 masked PHY0", 32'(d[16]), 32'd1);
    chk("R2 disabled PHY1", 32'(d[17]), 32'd0);
    wr(2'd0, 32'h0000_C000);
    idle(2);
    rd(2'd0, d);
    chk("R2 enabled PHY1", 32'(d[17]), 32'd1);
    chk("R12 enables read", 32'(d[15:14]), 32'd3);
  endtask

  task automatic t_wol();
    logic [31:0] d;
    do_reset();
    wr(2'd1, 32'h0000_0002);              // magic enable
    mac_magic_pkt = 1'b1;
    idle(3);
    rd(2'd0, d);
    chk("R3 wol disabled", 32'(d[5]), 32'd0);
    rd(2'd1, d);
    chk("R12 magic live", 32'(d[5]), 32'd1);
    mac_magic_pkt = 1'b0;
    wr(2'd0, 32'h0000_0200);              // wol enable
    mac_wake_frame = 1'b1;
    idle(3);
    rd(2'd0, d);
    chk("R3 frame without enable", 32'(d[5]), 32'd0);
    rd(2'd1, d);
    chk("R12 frame live", 32'(d[6]), 32'd1);
    wr(2'd1, 32'h0000_0004);              // frame enable
    idle(2);
    rd(2'd0, d);
    chk("R3 frame with enable", 32'(d[5]), 32'd1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    do_reset();
    wr(2'd0, 32'h0000_4200);
    wr(2'd1, 32'h0000_0002);
    phy_energy_on = 2'b01; phy_energy_mask = 2'b01; mac_magic_pkt = 1'b1;
    idle(2);
    wr(2'd0, 32'h0001_4220);              // clear both while sources active
    rd(2'd0, d);
    chk("R4 set wins ed", 32'(d[16]), 32'd1);
    chk("R4 set wins wol", 32'(d[5]), 32'd1);
    phy_energy_on = 2'b00; mac_magic_pkt = 1'b0;
    idle(2);
    rd(2'd0, d);
    chk("R4 sticky hold", 32'(d[16]), 32'd1);
    wr(2'd0, 32'h0001_4220);
    rd(2'd0, d);
    chk("R4 cleared ed", 32'(d[16]), 32'd0);
    chk("R4 cleared wol", 32'(d[5]), 32'd0);
  endtask

  task automatic t_level();
    do_reset();
    wr(2'd0, 32'h0000_4004);              // active-high, pin disabled
    phy_energy_on = 2'b01; phy_energy_mask = 2'b01;
    idle(4);
    chk("R5 pin disabled", 32'(pme_out), 32'd0);
    wr(2'd0, 32'h0000_4006);              // enable pin, level mode
    idle(2);
    chk("R6 level active", 32'(pme_out), 32'd1);
    chk("R8 active-high", 32'(pme_out), 32'd1);
    phy_energy_on = 2'b00;
    wr(2'd0, 32'h0001_4006);              // clear status
    idle(2);
    chk("R6 level released", 32'(pme_out), 32'd0);
    phy_energy_on = 2'b01;
    wr(2'd0, 32'h0000_4002);              // active-low
    idle(3);
    chk("R8 active-low", 32'(pme_out), 32'd0);
    chk("R9 push-pull oe", 32'(pme_oe), 32'd1);
  endtask

  task automatic t_pulse();
    int highs = 0;
    do_reset();
    wr(2'd1, 32'h0000_0002);
    wr(2'd0, 32'h0000_420E);              // pulse, active-high, pin on, wol, ed0
    phy_energy_on = 2'b01; phy_energy_mask = 2'b01;
    for (int c = 0; c < 3 * P; c++) begin
      @(negedge clk);
      if (c == 6) mac_magic_pkt = 1'b1;   // new event during pulse
      if (pme_out) highs++;
    end
    chk("R7 pulse width, no restart", 32'(highs), 32'(P));
  endtask

  task automatic t_od();
    do_reset();
    wr(2'd0, 32'h0000_4042);              // open-drain, active-low, level, pin on
    idle(2);
    chk("R9 od idle oe", 32'(pme_oe), 32'd0);
    phy_energy_on = 2'b01; phy_energy_mask = 2'b01;
    idle(3);
    chk("R9 od active oe", 32'(pme_oe), 32'd1);
    chk("R9 od active level", 32'(pme_out), 32'd0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    do_reset();
    other_irq = 1'b1;
    idle(2);
    chk("R11 other irq", 32'(irq), 32'd1);
    other_irq = 1'b0;
    wr(2'd0, 32'h0000_4000);
    phy_energy_on = 2'b01; phy_energy_mask = 2'b01;
    idle(3);
    rd(2'd2, d);
    chk("R10 int status set", 32'(d[17]), 32'd1);
    chk("R11 no enables", 32'(irq), 32'd0);
    wr(2'd3, 32'h0002_0000);
    idle(2);
    chk("R11 global off", 32'(irq), 32'd0);
    wr(2'd3, 32'h0002_0100);
    idle(2);
    chk("R11 irq on", 32'(irq), 32'd1);
    phy_energy_on = 2'b00;
    wr(2'd2, 32'h0002_0000);              // clear while status still set
    rd(2'd2, d);
    chk("R10 set wins", 32'(d[17]), 32'd1);
    wr(2'd0, 32'h0001_4000);
    wr(2'd2, 32'h0002_0000);
    idle(2);
    rd(2'd2, d);
    chk("R10 cleared", 32'(d[17]), 32'd0);
    chk("R11 irq off", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_energy();
    t_wol();
    t_clear();
    t_level();
    t_pulse();
    t_od();
    t_irq();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule